// File: doc/BRIEF.md
# Settling-Time Reliability Mask Generator

This test-time block screens a redundant array of noisy bit cells. Each cell is evaluated by an external saturating up/down voter shared through a multiplexer. The block selects one cell at a time and counts the voter trials that cell consumes. A cell whose voter reaches a terminal value within a programmable trial limit is kept as reliable. A cell that has not settled when the limit runs out is discarded. The result is a per-cell validity mask that carries no response values, so it can be published.

While the scan runs, the block also counts the valid cells. It packs the resolved values of the valid cells, in ascending cell order, into a key register. When the last cell has been classified, it raises a completion flag. It also compares the valid-cell count with the key length and reports whether the chip has enough reliable cells to be accepted.

Top module: `relmask_gen`

## Requirements
- R1: After reset, busy, done and chip_ok are 0, valid_mask, valid_count and key_out are all zeros, cell_sel is 0 and cell_adv is 0.
- R2: A start pulse while no scan is running (busy low) does three things on that clock edge: it latches trial_limit, clears the mask, count and key, and begins a scan at cell 0. A start pulse while busy is high is ignored, including its trial_limit.
- R3: If the voter reports settled (vote_vld and vote_settled both 1) on a trial whose number, counted from 1 for the current cell, is at most the latched limit, the cell's mask bit becomes 1.
- R4: If a cell has consumed the latched limit of trials without settling, it is decided invalid (mask bit 0) on the next clock edge without consuming a further trial. A limit of 0 marks every cell invalid, one cell per clock.
- R5: Cycles with vote_vld low, and all vote inputs while no scan is running, leave the trial count, mask, count and key unchanged.
- R6: Cells are classified in ascending index order. In the cycle after each decision other than the last, cell_adv is 1 for one cycle and cell_sel shows the next index.
- R7: valid_count always equals the number of 1 bits in valid_mask.
- R8: key_out bit k holds vote_bit of the k-th valid cell in ascending order, counting from 0. Valid cells beyond KEY_LEN are ignored, and key bits that no valid cell fills stay 0.
- R9: A valid cell's mask bit is 1 whichever terminal it resolved to (vote_bit 0 or 1).
- R10: busy is 1 exactly while a scan runs. done rises in the cycle after the last cell is decided and stays 1 until the next accepted start.
- R11: chip_ok is 1 only while done is 1 and valid_count is at least KEY_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new classification scan |
| trial_limit | input | TRIAL_W | Maximum trials allowed per cell, latched at start |
| vote_vld | input | 1 | One voter trial completed this cycle |
| vote_settled | input | 1 | Voter counter is at a terminal value after this trial |
| vote_bit | input | 1 | Terminal reached: 1 for the upper end, 0 for the lower end |
| cell_sel | output | $clog2(N_CELLS) | Index of the cell under test |
| cell_adv | output | 1 | One-cycle pulse: moved to a new cell, voter must re-centre |
| busy | output | 1 | Scan in progress |
| done | output | 1 | All cells classified |
| chip_ok | output | 1 | Enough valid cells for the key |
| valid_mask | output | N_CELLS | Per-cell validity, 1 means reliable |
| valid_count | output | $clog2(N_CELLS+1) | Number of valid cells |
| key_out | output | KEY_LEN | Packed responses of valid cells |

## Verification
The bench aims at the limit boundary. A cell settling exactly on the last allowed trial must be kept, and one needing a single trial more must be dropped. An off-by-one in the trial comparison flips those mask bits and shifts every later key bit. The bench also runs a zero limit, where a design that waits for a trial before checking the limit would stall or accept cells. A run with exactly KEY_LEN valid cells and one with a single cell short catch a wrong comparison in the reject decision. More valid cells than key bits, valid cells resolving to 0, vote noise on idle cycles, and a start pulse during a scan expose overwritten key bits, value-dependent masks, and state corruption by ignored inputs.

// File: rtl/rm_pkg.sv
package rm_pkg;
   typedef enum logic [1:0] {
      RM_IDLE = 2'd0,
      RM_SCAN = 2'd1,
      RM_DONE = 2'd2
   } rm_state_e;
endpackage

// File: rtl/rm_trial_timer.sv
module rm_trial_timer #(
   parameter int TRIAL_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [TRIAL_W-1:0] limit_in,
   input  logic               active,
   input  logic               vote_vld,
   input  logic               vote_settled,
   output logic               decide,
   output logic               decide_valid
);
   logic [TRIAL_W-1:0] thr_q;
   logic [TRIAL_W-1:0] tcnt_q;
   logic               spent;

   assign spent        = (tcnt_q >= thr_q);
   assign decide_valid = active && !spent && vote_vld && vote_settled;
   assign decide       = active && (spent || (vote_vld && vote_settled));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         tcnt_q <= '0;
      end else if (load) begin
         thr_q  <= limit_in;
         tcnt_q <= '0;
      end else if (active) begin
         if (decide)
            tcnt_q <= '0;
         else if (vote_vld)
            tcnt_q <= tcnt_q + 1'b1;
      end
   end

   AST_TRIAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt_q <= thr_q); // R4

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> $stable(tcnt_q)); // R5
endmodule

// File: rtl/rm_tally.sv
module rm_tally #(
   parameter int N_CELLS = 16,
   localparam int IDX_W  = $clog2(N_CELLS),
   localparam int CNT_W  = $clog2(N_CELLS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr,
   input  logic [IDX_W-1:0]   idx,
   input  logic               cell_ok,
   output logic [N_CELLS-1:0] mask,
   output logic [CNT_W-1:0]   count
);
   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask[i] <= 1'b0;
         else if (clr)
            mask[i] <= 1'b0;
         else if (wr && (idx == IDX_W'(i)))
            mask[i] <= cell_ok;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (wr && cell_ok)
         count <= count + 1'b1;
   end

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && cell_ok) |=> (count == $past(count) + 1'b1)); // R7
endmodule

// File: rtl/rm_key_packer.sv
module rm_key_packer #(
   parameter int KEY_LEN = 8,
   localparam int PTR_W  = $clog2(KEY_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr,
   input  logic               bit_in,
   output logic [KEY_LEN-1:0] key
);
   logic [PTR_W-1:0] ptr_q;
   logic             room;

   assign room = (ptr_q < PTR_W'(KEY_LEN));

   for (genvar k = 0; k < KEY_LEN; k++) begin : g_kbit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            key[k] <= 1'b0;
         else if (clr)
            key[k] <= 1'b0;
         else if (wr && (ptr_q == PTR_W'(k)))
            key[k] <= bit_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (clr)
         ptr_q <= '0;
      else if (wr && room)
         ptr_q <= ptr_q + 1'b1;
   end

   AST_KEY_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PTR_W'(KEY_LEN)); // R8

   AST_KEY_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!room && !clr) |=> $stable(key)); // R8
endmodule

// File: rtl/relmask_gen.sv
module relmask_gen #(
   parameter int N_CELLS = 16,
   parameter int KEY_LEN = 8,
   parameter int TRIAL_W = 8,
   localparam int IDX_W  = $clog2(N_CELLS),
   localparam int CNT_W  = $clog2(N_CELLS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [TRIAL_W-1:0] trial_limit,
   input  logic               vote_vld,
   input  logic               vote_settled,
   input  logic               vote_bit,
   output logic [IDX_W-1:0]   cell_sel,
   output logic               cell_adv,
   output logic               busy,
   output logic               done,
   output logic               chip_ok,
   output logic [N_CELLS-1:0] valid_mask,
   output logic [CNT_W-1:0]   valid_count,
   output logic [KEY_LEN-1:0] key_out
);
   import rm_pkg::*;

   if (N_CELLS < 2) begin : g_chk_cells
      $error("relmask_gen: N_CELLS must be at least 2");
   end
   if (KEY_LEN < 1 || KEY_LEN >= N_CELLS) begin : g_chk_key
      $error("relmask_gen: KEY_LEN must be in 1 .. N_CELLS-1 (redundant array)");
   end
   if (TRIAL_W < 1) begin : g_chk_trial
      $error("relmask_gen: TRIAL_W must be positive");
   end

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CELLS - 1);

   rm_state_e        state_q;
   logic [IDX_W-1:0] idx_q;
   logic             adv_q;
   logic             accept;
   logic             scanning;
   logic             decide;
   logic             decide_valid;

   assign scanning = (state_q == RM_SCAN);
   assign accept   = start && !scanning;

   rm_trial_timer #(.TRIAL_W(TRIAL_W)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (accept),
      .limit_in     (trial_limit),
      .active       (scanning),
      .vote_vld     (vote_vld),
      .vote_settled (vote_settled),
      .decide       (decide),
      .decide_valid (decide_valid)
   );

   rm_tally #(.N_CELLS(N_CELLS)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .wr      (decide),
      .idx     (idx_q),
      .cell_ok (decide_valid),
      .mask    (valid_mask),
      .count   (valid_count)
   );

   rm_key_packer #(.KEY_LEN(KEY_LEN)) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .wr     (decide_valid),
      .bit_in (vote_bit),
      .key    (key_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RM_IDLE;
         idx_q   <= '0;
         adv_q   <= 1'b0;
      end else begin
         adv_q <= 1'b0;
         if (accept) begin
            state_q <= RM_SCAN;
            idx_q   <= '0;
         end else if (scanning && decide) begin
            if (idx_q == LAST_IDX) begin
               state_q <= RM_DONE;
            end else begin
               idx_q <= idx_q + 1'b1;
               adv_q <= 1'b1;
            end
         end
      end
   end

   assign cell_sel = idx_q;
   assign cell_adv = adv_q;
   assign busy     = scanning;
   assign done     = (state_q == RM_DONE);
   assign chip_ok  = done && (valid_count >= CNT_W'(KEY_LEN));

   AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      valid_count == CNT_W'($countones(valid_mask))); // R7

   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      cell_adv |-> (cell_sel == $past(cell_sel) + 1'b1)); // R6

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done); // R10

   AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      chip_ok |-> done); // R11

   AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(valid_mask)); // R5

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> busy || done); // R2
endmodule

// File: tb/relmask_gen_bench.sv
module relmask_gen_bench;
   localparam int NC  = 16;
   localparam int KL  = 8;
   localparam int TW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [TW-1:0] trial_limit = '0;
   logic          vote_vld = 1'b0;
   logic          vote_settled = 1'b0;
   logic          vote_bit = 1'b0;
   logic [3:0]    cell_sel;
   logic          cell_adv;
   logic          busy;
   logic          done;
   logic          chip_ok;
   logic [NC-1:0] valid_mask;
   logic [4:0]    valid_count;
   logic [KL-1:0] key_out;

   relmask_gen #(.N_CELLS(NC), .KEY_LEN(KL), .TRIAL_W(TW)) u_relmask_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .trial_limit(trial_limit),
      .vote_vld(vote_vld), .vote_settled(vote_settled), .vote_bit(vote_bit),
      .cell_sel(cell_sel), .cell_adv(cell_adv), .busy(busy), .done(done),
      .chip_ok(chip_ok), .valid_mask(valid_mask), .valid_count(valid_count),
      .key_out(key_out)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit summary_done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference: 0 idle, 1 scanning, 2 finished
   int            m_state = 0;
   int            m_idx = 0;
   int            m_tcnt = 0;
   int            m_thr = 0;
   int            m_cnt = 0;
   int            m_ptr = 0;
   bit            m_adv = 0;
   logic [NC-1:0] m_mask = '0;
   logic [KL-1:0] m_key = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_idx = 0; m_tcnt = 0; m_thr = 0; m_cnt = 0;
         m_ptr = 0; m_adv = 0; m_mask = '0; m_key = '0;
      end else begin
         bit dec, ok, rb;
         dec = 0; ok = 0; rb = 0;
         m_adv = 0;
         if (start && m_state != 1) begin
            m_state = 1; m_idx = 0; m_tcnt = 0; m_thr = int'(trial_limit);
            m_cnt = 0; m_ptr = 0; m_mask = '0; m_key = '0;
         end else if (m_state == 1) begin
            if (m_tcnt >= m_thr) begin
               dec = 1;
            end else if (vote_vld) begin
               m_tcnt++;
               if (vote_settled) begin dec = 1; ok = 1; rb = vote_bit; end
            end
            if (dec) begin
               m_mask[m_idx] = ok;
               if (ok) begin
                  m_cnt++;
                  if (m_ptr < KL) begin m_key[m_ptr] = rb; m_ptr++; end
               end
               m_tcnt = 0;
               if (m_idx == NC - 1) m_state = 2;
               else begin m_idx++; m_adv = 1; end
            end
         end
      end
   end

   // per-clock comparison, sampled after the edge settles
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            chk(busy == (m_state == 1), "R10", "busy", busy, m_state == 1);
            chk(done == (m_state == 2), "R10", "done", done, m_state == 2);
            chk(int'(cell_sel) == m_idx, "R6", "cell_sel", cell_sel, m_idx);
            chk(cell_adv == m_adv, "R6", "cell_adv", cell_adv, m_adv);
            chk(valid_mask == m_mask, "R3", "mask", valid_mask, m_mask);
            chk(int'(valid_count) == m_cnt, "R7", "count", valid_count, m_cnt);
            chk(key_out == m_key, "R8", "key", key_out, m_key);
            chk(chip_ok == (m_state == 2 && m_cnt >= KL), "R11", "chip_ok",
                chip_ok, (m_state == 2 && m_cnt >= KL));
         end
      end
   end

   // trial on which each cell settles (0 = never) and its resolved value
   int plan [NC];
   bit pbit [NC];
   logic [31:0] lfsr = 32'h1234_5678;

   task automatic load_plan_a();
      int p [NC] = '{1,4,5,0,2,3,1,4,6,1,2,0,3,1,4,2};
      logic [NC-1:0] b = 16'b1010_0110_1100_0011;
      for (int i = 0; i < NC; i++) begin plan[i] = p[i]; pbit[i] = b[i]; end
   endtask

   task automatic load_plan_b();
      for (int i = 0; i < NC; i++) begin
         plan[i] = (i < KL) ? 1 + (i % 3) : 0;
         pbit[i] = i[0];
      end
   endtask

   task automatic run_scan(input int thr, input bit gaps, input bit poke);
      int cyc;
      @(negedge clk);
      start = 1; trial_limit = TW'(thr); vote_vld = 0;
      @(negedge clk);
      start = 0;
      cyc = 0;
      while (m_state != 2 && cyc < 3000) begin
         bit v;
         cyc++;
         lfsr = lfsr * 32'd1103515245 + 32'd12345;
         v = gaps ? (lfsr[17:16] != 2'b00) : 1'b1;
         vote_vld = v;
         if (v) begin
            vote_settled = (plan[m_idx] != 0) && (plan[m_idx] == m_tcnt + 1);
            vote_bit     = pbit[m_idx];
         end else begin
            vote_settled = lfsr[5];
            vote_bit     = lfsr[9];
         end
         start       = poke && (cyc == 10);
         trial_limit = (poke && cyc == 10) ? TW'(1) : TW'(thr);
         @(negedge clk);
      end
      if (cyc >= 3000) chk(0, "R10", "scan watchdog", cyc, 0);
      start = 0; vote_vld = 0; vote_settled = 0;
   endtask

   task automatic check_result(input int thr, input string req);
      logic [NC-1:0] em = '0;
      logic [KL-1:0] ek = '0;
      int ec = 0;
      for (int i = 0; i < NC; i++) begin
         if (plan[i] >= 1 && plan[i] <= thr) begin
            em[i] = 1'b1;
            if (ec < KL) ek[ec] = pbit[i];
            ec++;
         end
      end
      @(negedge clk);
      chk(done == 1'b1, "R10", "done after scan", done, 1);
      chk(valid_mask == em, req, "final mask (R3 R4 R9)", valid_mask, em);
      chk(int'(valid_count) == ec, "R7", "final count", valid_count, ec);
      chk(key_out == ek, "R8", "final key", key_out, ek);
      chk(chip_ok == (ec >= KL), "R11", "chip_ok", chip_ok, ec >= KL);
      // idle vote noise must not disturb results
      for (int j = 0; j < 6; j++) begin
         vote_vld = 1; vote_settled = 1; vote_bit = j[0];
         @(negedge clk);
      end
      vote_vld = 0; vote_settled = 0;
      chk(valid_mask == em, "R5", "mask after idle votes", valid_mask, em);
      chk(key_out == ek, "R5", "key after idle votes", key_out, ek);
      chk(done == 1'b1, "R10", "done held", done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && chip_ok == 0, "R1", "flags in reset",
          {busy, done, chip_ok}, 0);
      chk(valid_mask == '0 && valid_count == '0 && key_out == '0, "R1",
          "results in reset", valid_mask, 0);
      chk(cell_sel == '0 && cell_adv == 0, "R1", "cell_sel in reset", cell_sel, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(busy == 0 && done == 0, "R1", "idle after reset", busy, 0);

      // limit 4, gaps, surplus valid cells, start poke mid-scan (R2)
      load_plan_a();
      run_scan(4, 1'b1, 1'b1);
      check_result(4, "R3");

      // restart from done with limit 2: one cell short of the key
      run_scan(2, 1'b1, 1'b0);
      check_result(2, "R2");

      // zero limit: every cell rejected
      run_scan(0, 1'b0, 1'b0);
      check_result(0, "R4");

      // exactly KEY_LEN valid cells
      load_plan_b();
      run_scan(3, 1'b1, 1'b0);
      check_result(3, "R11");

      if (!summary_done) begin
         summary_done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end

   initial begin
      #(5 * 150000);
      if (!summary_done) begin
         summary_done = 1;
         checks++; fails++;
         $display("FAIL R10 watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end
endmodule